// File: doc/BRIEF.md
# Sector Field Gap Sequencer

This block paces a sector that holds three records in a fixed order: header, then label, then data. It tracks time in word units, where one word is a run of bit cells. From that count it decides when the read gate and the write gate open and close. Each record can be read or rewritten on its own. A record can also be rewritten straight after a record that was only read, and the new preamble then lands cleanly inside the zero gap that was written earlier. The block drives no bits itself. It asks the bit encoder for zero fill and for the sync bit, it waits for the bit decoder to report sync, and it gives a memory transfer engine one single-cycle strobe for each word.

A sector starts with a `start` pulse. The three-bit `mode` is latched at that pulse and sets, for each record, whether it is read or written. Between records the gap is four trailing zero words followed by five leading zero words, so nine words in all, and then the sync bit. On a read, the block closes the read gate as soon as the checksum word has passed. It opens the gate again at the middle of the nine-word gap. On a write, the block waits one word into the old trailing zeros and then writes the whole gap again. Because of this, the first few microseconds after the write gate rises, which are unreliable, fall inside a span that readers skip.

Top module: `sector_gap_seq`

## Requirements
- R1: While reset is held and in the cycle after it, read_gate, write_gate, zero_fill, sync_req, mem_trig, done, busy and sync_err are all low.
- R2: mode bit 0 selects the header, bit 1 the label and bit 2 the data record, and a 1 means write. The value is captured on the cycle that start is accepted in the idle state.
- R3: For a read record, read_gate rises exactly (POST+PRE)/2 word times, which is 4.5 words, after the previous checksum word ends. Sector start counts as such an end. read_gate falls in the cycle right after the record's own checksum word.
- R4: For a write record, write_gate rises exactly one word time after the previous checksum word ends. zero_fill then stays high for nine words, and sync_req is then high for exactly one cycle with write_gate high.
- R5: After a written checksum word, write_gate stays high for four more word times and then falls. It does not fall if the next record is also written.
- R6: mem_trig is high for exactly one clock, on the last clock of each body word. Each record gives as many strobes as it has words, checksum included.
- R7: read_gate and write_gate are never high in the same cycle.
- R8: A read body starts on the clock after sync_seen. A sync reported in the last clock of the timeout window is still accepted.
- R9: If sync_seen does not arrive within SYNC_TMO clocks of read_gate rising, sync_err sets, both gates drop, the block goes idle and done does not pulse. The next accepted start clears sync_err.
- R10: done is a one-clock pulse. It comes after the data record's checksum, or after its four trailing zero words if the data record is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sector (honoured when idle) |
| mode | input | 3 | Per-record write select: bit 0 header, 1 label, 2 data |
| sync_seen | input | 1 | Decoder found the sync bit |
| read_gate | output | 1 | Enable the read channel |
| write_gate | output | 1 | Enable the write and erase heads |
| zero_fill | output | 1 | Encoder must emit zero data bits |
| sync_req | output | 1 | Encoder must emit the single sync 1 bit |
| mem_trig | output | 1 | One-clock strobe per body word |
| mem_write | output | 1 | Current record is being written |
| field_sel | output | 2 | Current record: 0 header, 1 label, 2 data |
| busy | output | 1 | A sector is in progress |
| done | output | 1 | One-clock end-of-sector pulse |
| sync_err | output | 1 | Sticky sync timeout flag |

## Verification
Some properties are checked on every cycle. The two gates must never be high together. The memory strobe and the done pulse must each last one clock. A sync request may only appear while the write gate is open. A rise of the timeout flag must come with both gates closed. Other behaviour is only visible in the bench scenarios. These cover the exact word-time offsets of the gate edges measured from each checksum, the number of zero-fill cycles, strobe counts for each record, and total sector length for all eight read/write mixes. They also cover the sync accepted at the last timeout clock, and the timeout path followed by a clean restart.

// File: rtl/gapseq_pkg.sv
package gapseq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_GAP,
        SQ_SYNCW,
        SQ_SYNCO,
        SQ_BODY,
        SQ_TAIL,
        SQ_DONE
    } seq_state_e;

    // zero words after a checksum, zero words before a sync, write delay
    localparam int POST_WORDS = 4;
    localparam int PRE_WORDS  = 5;
    localparam int LEAD_WORDS = 1;

    localparam logic [1:0] FLD_HDR = 2'd0;
    localparam logic [1:0] FLD_LBL = 2'd1;
    localparam logic [1:0] FLD_DAT = 2'd2;

    typedef struct packed {
        logic rd;
        logic wr;
        logic zero;
        logic sync;
    } gate_t;

    function automatic logic field_writes(input logic [2:0] m, input logic [1:0] f);
        case (f)
            FLD_HDR: return m[0];
            FLD_LBL: return m[1];
            default: return m[2];
        endcase
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int r;
        r = (a > b) ? a : b;
        return (r > c) ? r : c;
    endfunction

endpackage

// File: rtl/gapseq_word_timer.sv
module gapseq_word_timer #(
    parameter int CLKS = 480,
    parameter int WW   = 9,
    localparam int CW  = $clog2(CLKS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    output logic [WW-1:0] word,
    output logic [CW-1:0] phase,
    output logic          word_end
);

    assign word_end = (phase == CW'(CLKS - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase <= '0;
            word  <= '0;
        end else if (en) begin
            if (word_end) begin
                phase <= '0;
                word  <= word + 1'b1;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

endmodule

// File: rtl/gapseq_sync_watch.sv
module gapseq_sync_watch #(
    parameter int TMO = 5760,
    localparam int TW = $clog2(TMO + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic expire
);

    logic [TW-1:0] cnt;

    assign expire = en && (cnt == TW'(TMO - 1));

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (en && !expire)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/sector_gap_seq.sv
module sector_gap_seq
    import gapseq_pkg::*;
#(
    parameter int WORD_CLKS = 480,
    parameter int HDR_WORDS = 2,
    parameter int LBL_WORDS = 8,
    parameter int DAT_WORDS = 256,
    parameter int SYNC_TMO  = 5760
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [2:0] mode,
    input  logic       sync_seen,
    output logic       read_gate,
    output logic       write_gate,
    output logic       zero_fill,
    output logic       sync_req,
    output logic       mem_trig,
    output logic       mem_write,
    output logic [1:0] field_sel,
    output logic       busy,
    output logic       done,
    output logic       sync_err
);

    localparam int GAP_WORDS = POST_WORDS + PRE_WORDS;
    localparam int GAP_END   = LEAD_WORDS + GAP_WORDS - 1;
    localparam int MAXW      = max3(max3(HDR_WORDS, LBL_WORDS, DAT_WORDS), GAP_END + 1, POST_WORDS);
    localparam int WW        = $clog2(MAXW + 1);
    localparam int CW        = $clog2(WORD_CLKS);
    // read re-enable point: middle of the zero gap
    localparam int RE_WORD   = (GAP_WORDS % 2 == 1) ? GAP_WORDS / 2 : GAP_WORDS / 2 - 1;
    localparam int RE_CLK    = (GAP_WORDS % 2 == 1) ? WORD_CLKS / 2 - 1 : WORD_CLKS - 1;

    localparam logic [WW-1:0] W_GAP_END = WW'(GAP_END);
    localparam logic [WW-1:0] W_RE      = WW'(RE_WORD);
    localparam logic [WW-1:0] W_POST    = WW'(POST_WORDS);
    localparam logic [WW-1:0] W_LEAD    = WW'(LEAD_WORDS);
    localparam logic [CW-1:0] C_RE      = CW'(RE_CLK);

    seq_state_e    st, nxt;
    logic [2:0]    mode_q;
    logic [1:0]    fld;
    logic          prev_wr, cur_wr, err_q;
    logic          tclr, wclr, t_en;
    logic [WW-1:0] word, last_word;
    logic [CW-1:0] phase;
    logic          word_end, expire;
    gate_t         g;

    assign cur_wr = field_writes(mode_q, fld);
    assign t_en   = (st == SQ_GAP) || (st == SQ_BODY) || (st == SQ_TAIL);

    always_comb begin
        case (fld)
            FLD_HDR: last_word = WW'(HDR_WORDS - 1);
            FLD_LBL: last_word = WW'(LBL_WORDS - 1);
            default: last_word = WW'(DAT_WORDS - 1);
        endcase
    end

    gapseq_word_timer #(.CLKS(WORD_CLKS), .WW(WW)) timer_i (
        .clk(clk), .rst(rst), .clr(tclr), .en(t_en),
        .word(word), .phase(phase), .word_end(word_end)
    );

    gapseq_sync_watch #(.TMO(SYNC_TMO)) watch_i (
        .clk(clk), .rst(rst), .clr(wclr), .en(st == SQ_SYNCW), .expire(expire)
    );

    // next-state and counter clears
    always_comb begin
        nxt  = st;
        tclr = 1'b0;
        wclr = 1'b0;
        unique case (st)
            SQ_IDLE: if (start) begin nxt = SQ_GAP; tclr = 1'b1; end
            SQ_GAP: begin
                if (cur_wr) begin
                    if (word == W_GAP_END && word_end) nxt = SQ_SYNCO;
                end else if (word == W_RE && phase == C_RE) begin
                    nxt  = SQ_SYNCW;
                    wclr = 1'b1;
                end
            end
            SQ_SYNCW: begin
                if (sync_seen) begin nxt = SQ_BODY; tclr = 1'b1; end
                else if (expire) nxt = SQ_IDLE;
            end
            SQ_SYNCO: begin nxt = SQ_BODY; tclr = 1'b1; end
            SQ_BODY: begin
                if (word_end && word == last_word) begin
                    tclr = 1'b1;
                    if (fld == FLD_DAT) nxt = cur_wr ? SQ_TAIL : SQ_DONE;
                    else                nxt = SQ_GAP;
                end
            end
            SQ_TAIL: if (word_end && word == W_POST - 1'b1) nxt = SQ_DONE;
            SQ_DONE: nxt = SQ_IDLE;
            default: nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_IDLE;
            mode_q  <= '0;
            fld     <= FLD_HDR;
            prev_wr <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            st <= nxt;
            if (st == SQ_IDLE && start) begin
                mode_q  <= mode;
                fld     <= FLD_HDR;
                prev_wr <= 1'b0;
                err_q   <= 1'b0;
            end
            if (st == SQ_BODY && nxt == SQ_GAP) begin
                fld     <= fld + 1'b1;
                prev_wr <= cur_wr;
            end
            if (st == SQ_SYNCW && expire && !sync_seen)
                err_q <= 1'b1;
        end
    end

    // gate decode
    always_comb begin
        g = '0;
        unique case (st)
            SQ_GAP: begin
                g.wr   = (prev_wr && word < W_POST) || (cur_wr && word >= W_LEAD);
                g.zero = g.wr;
            end
            SQ_SYNCW: g.rd = 1'b1;
            SQ_SYNCO: begin g.wr = 1'b1; g.sync = 1'b1; end
            SQ_BODY:  begin g.rd = !cur_wr; g.wr = cur_wr; end
            SQ_TAIL:  begin g.wr = 1'b1; g.zero = 1'b1; end
            default: ;
        endcase
    end

    assign read_gate  = g.rd;
    assign write_gate = g.wr;
    assign zero_fill  = g.zero;
    assign sync_req   = g.sync;
    assign mem_trig   = (st == SQ_BODY) && word_end;
    assign mem_write  = cur_wr && busy;
    assign field_sel  = fld;
    assign busy       = (st != SQ_IDLE);
    assign done       = (st == SQ_DONE);
    assign sync_err   = err_q;

    // R7
    gate_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(read_gate && write_gate));

    // R6
    trig_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_trig |=> !mem_trig);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4
    sync_gate_chk: assert property (@(posedge clk) disable iff (rst)
        sync_req |=> (write_gate && !sync_req));

    // R9
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_err) |-> (!read_gate && !write_gate && !done));

endmodule

// File: tb/sector_gap_seq_tb_top.sv
module sector_gap_seq_tb_top;

    localparam int W   = 8;
    localparam int NH  = 2;
    localparam int NL  = 3;
    localparam int ND  = 4;
    localparam int TMO = 40;
    localparam int RE_OFF   = 36;  // 4.5 words
    localparam int WR_OFF   = W;   // one word
    localparam int POST_OFF = 4 * W;

    // {mode[2:0], sync delay[5:0]}
    localparam logic [8:0] VEC [8] = '{
        {3'b000, 6'd5},  {3'b001, 6'd1},  {3'b010, 6'd40}, {3'b011, 6'd7},
        {3'b100, 6'd3},  {3'b101, 6'd12}, {3'b110, 6'd2},  {3'b111, 6'd9}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [2:0] mode = '0;
    logic sync_seen = 1'b0;
    logic read_gate, write_gate, zero_fill, sync_req, mem_trig, mem_write;
    logic [1:0] field_sel;
    logic busy, done, sync_err;

    int n_checks = 0;
    int n_errs   = 0;
    int sd       = 0;
    int rg_cnt   = 0;

    always #10 clk = ~clk;

    sector_gap_seq #(
        .WORD_CLKS(W), .HDR_WORDS(NH), .LBL_WORDS(NL), .DAT_WORDS(ND), .SYNC_TMO(TMO)
    ) dut_i (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .sync_seen(sync_seen),
        .read_gate(read_gate), .write_gate(write_gate), .zero_fill(zero_fill),
        .sync_req(sync_req), .mem_trig(mem_trig), .mem_write(mem_write),
        .field_sel(field_sel), .busy(busy), .done(done), .sync_err(sync_err)
    );

    // reader model: report sync sd clocks after read_gate opens (0 = never)
    initial begin
        forever begin
            @(negedge clk);
            if (read_gate) rg_cnt = rg_cnt + 1;
            else           rg_cnt = 0;
            sync_seen = (sd != 0) && (rg_cnt == sd);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int rec_words(input int f);
        return (f == 0) ? NH : (f == 1) ? NL : ND;
    endfunction

    function automatic int exp_total(input logic [2:0] m, input int d);
        int t = 0;
        for (int f = 0; f < 3; f++)
            t += (m[f] ? (10 * W + 1) : (RE_OFF + d)) + rec_words(f) * W;
        if (m[2]) t += POST_OFF;
        return t;
    endfunction

    function automatic int exp_zero(input logic [2:0] m);
        int z = 0;
        for (int f = 0; f < 3; f++) begin
            logic pw = (f > 0) ? m[f-1] : 1'b0;
            if (m[f]) z += 9 * W + (pw ? W : 0);
            else      z += pw ? POST_OFF : 0;
        end
        if (m[2]) z += POST_OFF;
        return z;
    endfunction

    function automatic int exp_wrise(input logic [2:0] m);
        int r = 0;
        for (int f = 0; f < 3; f++)
            if (m[f] && !(f > 0 && m[f-1])) r++;
        return r;
    endfunction

    task automatic run_sector(input logic [2:0] m, input int d);
        int n = 0, trigs = 0, rrise = 0, wrise = 0, syncs = 0, zc = 0, gap_start = 0;
        bit seen_done = 0;
        logic prg = 0, pwg = 0, ptr = 0;
        sd = d;
        @(negedge clk);
        mode  = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (n < 1000) begin
            if (mem_trig) begin
                trigs++;
                gap_start = n + 1;
                check(!ptr, "R6 strobe width", 2, 1);
            end
            if (read_gate && !prg) begin
                rrise++;
                check(n - gap_start == RE_OFF, "R3 read reopen offset", n - gap_start, RE_OFF);
            end
            if (!read_gate && prg)
                check(n == gap_start, "R3 read close after checksum", n, gap_start);
            if (write_gate && !pwg) begin
                wrise++;
                check(n - gap_start == WR_OFF, "R4 write gate rise offset", n - gap_start, WR_OFF);
            end
            if (!write_gate && pwg)
                check(n - gap_start == POST_OFF, "R5 postamble length", n - gap_start, POST_OFF);
            if (sync_req) begin
                syncs++;
                check(write_gate, "R4 sync inside write gate", 0, 1);
            end
            if (zero_fill) zc++;
            if (read_gate && write_gate) check(0, "R7 gates overlap", 1, 0);
            if (done) begin
                seen_done = 1;
                check(n == exp_total(m, d), "R8/R10 sector length", n, exp_total(m, d));
                break;
            end
            prg = read_gate; pwg = write_gate; ptr = mem_trig;
            @(negedge clk);
            n++;
        end
        check(seen_done, "R10 done seen", 0, 1);
        check(trigs == NH + NL + ND, "R6 strobe count", trigs, NH + NL + ND);
        check(rrise == 3 - $countones(m), "R2 read record count", rrise, 3 - $countones(m));
        check(wrise == exp_wrise(m), "R2/R5 write gate rises", wrise, exp_wrise(m));
        check(syncs == $countones(m), "R4 sync requests", syncs, $countones(m));
        check(zc == exp_zero(m), "R4 zero fill cycles", zc, exp_zero(m));
        check(!sync_err, "R9 no error on good sector", 1, 0);
        @(negedge clk);
        check(!done && !busy, "R10 single done pulse", int'(done), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(!read_gate && !write_gate && !busy && !done, "R1 outputs in reset", int'(busy), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!read_gate && !write_gate && !zero_fill && !sync_req, "R1 gates after reset", int'(write_gate), 0);
        check(!mem_trig && !done && !busy && !sync_err, "R1 status after reset", int'(busy), 0);

        foreach (VEC[i]) run_sector(VEC[i][8:6], int'(VEC[i][5:0]));

        // R9: reader never syncs
        begin
            int n = 0;
            bit bad_done = 0;
            sd = 0;
            @(negedge clk);
            mode  = 3'b000;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            while (n <= 120) begin
                if (done) bad_done = 1;
                if (n == RE_OFF + TMO - 1)
                    check(read_gate && !sync_err, "R9 waiting before timeout", int'(sync_err), 0);
                if (n == RE_OFF + TMO) begin
                    check(sync_err, "R9 error flag at timeout", int'(sync_err), 1);
                    check(!read_gate && !write_gate && !busy, "R9 gates off and idle", int'(busy), 0);
                end
                @(negedge clk);
                n++;
            end
            check(!bad_done, "R9 no done after timeout", int'(bad_done), 0);
        end

        run_sector(3'b000, 4);  // R9: start clears the flag

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule